// File: doc/BRIEF.md
# Ratio-Halving Clock Divider

This block derives a slower clock from a reference clock. At build time the parameter `DIV` selects a nominal divide ratio of 2 or 4. At run time a step-down request halves that ratio. With `DIV = 4` the output falls back to the reference divided by two. With `DIV = 2` the output becomes a copy of the reference clock itself. A scan-mode input overrides the request, so a scan pattern always sees the nominal ratio.

The request arrives from another clock domain. It passes through a two-flop synchroniser on the reference clock before it is used. A new ratio never takes effect in the middle of a high phase. The switch waits until the divided clock is low, so a ratio change cannot produce a runt pulse. Once the effective request has been stable for 20 reference cycles, the output runs in its new steady pattern.

Top module: `stepdiv_clk`

## Requirements
- R1: With no effective step-down, the output period is `DIV` reference cycles, with each high phase and each low phase lasting `DIV/2` reference cycles.
- R2: The effective step-down condition is the request AND NOT scan mode. While scan mode is high, the block runs at its nominal ratio, whatever the request.
- R3: With `DIV = 2` and step-down in effect, the output is high during each reference high phase and low during each reference low phase.
- R4: With `DIV = 4` and step-down in effect, the output period is 2 reference cycles: one cycle high, then one cycle low.
- R5: After the effective step-down condition changes and then holds, the output shows its new steady pattern within 20 reference cycles.
- R6: The request is synchronised by two flops clocked on the reference rising edge. Once the request has held one value on three successive rising edges, the synchronised copy equals it.
- R7: A ratio change is applied only while the divided clock is low. No output high or low pulse is shorter than half a reference period.
- R8: The reset is synchronous and active low. While it is asserted the output is low. After release, counting starts from zero, so the output first rises on the `DIV/2`-th reference rising edge.
- R9: Each phase of the counter-driven output lasts exactly the nominal half period (`DIV/2`) or the stepped half period (`DIV/4`) in reference cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ref_clk | input | 1 | Reference clock to be divided |
| rst_n | input | 1 | Synchronous active-low reset |
| step_req | input | 1 | Asynchronous request to halve the divide ratio |
| scan_mode | input | 1 | High forces the nominal ratio |
| clk_out | output | 1 | Divided clock |

## Verification
Several properties are checked on every reference edge by the assertions:
- the synchroniser converges once the request is stable;
- every counter phase has one of the two legal lengths;
- the ratio select only moves while the divided clock is low;
- a held scan mode always drives the block back to its nominal selection.

Other behaviour shows only in the bench scenarios. These cover the whole output waveform in each mode: following the reference for `DIV = 2`, the half-rate and quarter-rate patterns, settling inside the 20-cycle window after each change, and the absence of runt pulses across the pass-through switch.

// File: rtl/stepdiv_pkg.sv
`timescale 1ns/1ps
package stepdiv_pkg;
  // Bits needed to count from 0 up to n-1 (at least one bit).
  function automatic int cnt_width(int n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/stepdiv_sync.sv
`timescale 1ns/1ps
module stepdiv_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  localparam int SW = $clog2(STAGES + 1);

  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], d_i};
  end

  assign q_o = chain[STAGES-1];

  // Checker: track how long the input has been stable (pre-reset history = 0).
  logic          prev_d;
  logic [SW-1:0] stab;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_d <= 1'b0;
      stab   <= '0;
    end else begin
      prev_d <= d_i;
      if (d_i != prev_d)               stab <= '0;
      else if (stab != SW'(STAGES))    stab <= stab + 1'b1;
    end
  end

  assert_sync_settles_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (stab >= SW'(STAGES - 1) && d_i == prev_d) |-> (q_o == d_i));
endmodule

// File: rtl/stepdiv_core.sv
`timescale 1ns/1ps
module stepdiv_core #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic step_i,
  output logic div_o,
  output logic stepped_o
);
  localparam int HALF_NOM  = DIV / 2;
  localparam int HALF_STEP = DIV / 4;
  localparam int CW        = stepdiv_pkg::cnt_width(HALF_NOM);

  logic [CW-1:0] cnt;
  logic [CW-1:0] limit;
  logic          div_q;
  logic          half_sel;
  logic          wrap;

  always_comb begin
    limit = half_sel ? CW'(HALF_STEP - 1) : CW'(HALF_NOM - 1);
    wrap  = (cnt == limit);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt   <= '0;
      div_q <= 1'b0;
    end else if (wrap) begin
      cnt   <= '0;
      div_q <= ~div_q;
    end else begin
      cnt   <= cnt + 1'b1;
    end
  end

  generate
    if (HALF_STEP > 0) begin : g_step
      // New ratio loaded only as the divided clock falls.
      always_ff @(posedge clk) begin
        if (!rst_n)              half_sel <= 1'b0;
        else if (wrap && div_q)  half_sel <= step_i;
      end
    end else begin : g_nostep
      logic unused_step;
      assign unused_step = step_i;
      assign half_sel    = 1'b0;
    end
  endgenerate

  assign div_o     = div_q;
  assign stepped_o = half_sel;

  // Checker: phase length of the counter-driven clock.
  logic       prev_q;
  logic [2:0] run;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      run    <= '0;
    end else begin
      prev_q <= div_q;
      if (div_q != prev_q)  run <= 3'd1;
      else if (run != 3'd7) run <= run + 1'b1;
    end
  end

  assert_phase_len_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (div_q != prev_q) |-> (run == 3'(HALF_NOM) || run == 3'(HALF_STEP)));

  assert_sel_moves_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(half_sel) |-> !div_q);
endmodule

// File: rtl/stepdiv_passsel.sv
`timescale 1ns/1ps
module stepdiv_passsel (
  input  logic clk,
  input  logic rst_n,
  input  logic step_i,
  input  logic div_i,
  output logic clk_o,
  output logic pass_o
);
  logic pass_q;

  // Select flips on the falling reference edge while the divided clock
  // is low, so both mux inputs are low at the switch instant.
  always_ff @(negedge clk) begin
    if (!rst_n)      pass_q <= 1'b0;
    else if (!div_i) pass_q <= step_i;
  end

  assign clk_o  = pass_q ? clk : div_i;
  assign pass_o = pass_q;

  assert_pass_switch_low_R7: assert property (@(negedge clk) disable iff (!rst_n)
    !$stable(pass_q) |-> !$past(div_i));
endmodule

// File: rtl/stepdiv_clk.sv
`timescale 1ns/1ps
module stepdiv_clk #(
  parameter int DIV = 2
) (
  input  logic ref_clk,
  input  logic rst_n,
  input  logic step_req,
  input  logic scan_mode,
  output logic clk_out
);
  localparam int SYNC_STAGES = 2;
  localparam int SCAN_SAT    = 15;

  logic req_s;
  logic step_eff;
  logic div_clk;
  logic core_stepped;
  logic mode_stepped;

  stepdiv_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (ref_clk),
    .rst_n (rst_n),
    .d_i   (step_req),
    .q_o   (req_s)
  );

  assign step_eff = req_s & ~scan_mode;

  stepdiv_core #(.DIV(DIV)) u_core (
    .clk       (ref_clk),
    .rst_n     (rst_n),
    .step_i    (step_eff),
    .div_o     (div_clk),
    .stepped_o (core_stepped)
  );

  generate
    if (DIV == 2) begin : g_pass
      logic unused_core;
      assign unused_core = core_stepped;
      stepdiv_passsel u_sel (
        .clk    (ref_clk),
        .rst_n  (rst_n),
        .step_i (step_eff),
        .div_i  (div_clk),
        .clk_o  (clk_out),
        .pass_o (mode_stepped)
      );
    end else begin : g_reg
      assign clk_out      = div_clk;
      assign mode_stepped = core_stepped;
    end
  endgenerate

  // Checker: a long-held scan mode must leave the stepped selection off.
  logic [3:0] scan_run;

  always_ff @(posedge ref_clk) begin
    if (!rst_n || !scan_mode)      scan_run <= '0;
    else if (scan_run != SCAN_SAT) scan_run <= scan_run + 1'b1;
  end

  assert_scan_forces_nominal_R2: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (scan_run == 4'(SCAN_SAT)) |-> !mode_stepped);
endmodule

// File: tb/stepdiv_clk_test.sv
`timescale 1ns/1ps
module stepdiv_clk_test;
  logic ref_clk = 1'b0;
  logic rst_n   = 1'b0;
  logic step_req  = 1'b0;
  logic scan_mode = 1'b0;
  logic out2, out4;
  int   checks = 0;
  int   fails  = 0;
  bit   done   = 0;

  always #10 ref_clk = ~ref_clk;   // 50 MHz

  stepdiv_clk #(.DIV(2)) uut (
    .ref_clk(ref_clk), .rst_n(rst_n), .step_req(step_req),
    .scan_mode(scan_mode), .clk_out(out2));

  stepdiv_clk #(.DIV(4)) uut4 (
    .ref_clk(ref_clk), .rst_n(rst_n), .step_req(step_req),
    .scan_mode(scan_mode), .clk_out(out4));

  // Runt-pulse monitor: sample at quarter points of the reference period.
  logic prv [2];
  int   run [2];
  int   viol[2];

  initial begin
    for (int k = 0; k < 2; k++) begin
      run[k] = -1; viol[k] = 0; prv[k] = 1'b0;
    end
  end

  task automatic mon_step();
    for (int k = 0; k < 2; k++) begin
      logic v;
      v = (k == 0) ? out2 : out4;
      if (!rst_n) run[k] = -1;
      else if (run[k] < 0) begin prv[k] = v; run[k] = 2; end
      else if (v == prv[k]) run[k]++;
      else begin
        if (run[k] < 2) viol[k]++;
        run[k] = 1; prv[k] = v;
      end
    end
  endtask

  always @(ref_clk) begin
    #2.5; mon_step();
    #5;   mon_step();
  end

  // Model: expected (high-sample, low-sample) pattern over 8 reference cycles.
  // mode 0: follows reference; mode 1: period 2; mode 2: period 4.
  function automatic logic [15:0] expect_pat(int mode, logic h0, logic h1);
    logic [15:0] e;
    for (int i = 0; i < 8; i++) begin
      logic v;
      case (mode)
        0: begin e[15-2*i] = 1'b1; e[14-2*i] = 1'b0; end
        1: begin v = h0 ^ i[0]; e[15-2*i] = v; e[14-2*i] = v; end
        default: begin
          if (h0 == h1) v = h0 ^ ((i >> 1) & 1);
          else          v = h0 ^ (((i + 1) >> 1) & 1);
          e[15-2*i] = v; e[14-2*i] = v;
        end
      endcase
    end
    return e;
  endfunction

  task automatic collect(output logic [15:0] a2, output logic [15:0] a4);
    for (int i = 0; i < 8; i++) begin
      @(posedge ref_clk); #5;
      a2[15-2*i] = out2; a4[15-2*i] = out4;
      @(negedge ref_clk); #5;
      a2[14-2*i] = out2; a4[14-2*i] = out4;
    end
  endtask

  task automatic check_pat(string req, string what, logic [15:0] act, int mode);
    logic [15:0] exp;
    exp = expect_pat(mode, act[15], act[13]);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic check_bit(string req, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic scenario(logic req, logic scan, string tag, int m2, int m4);
    logic [15:0] a2, a4;
    step_req  = req;
    scan_mode = scan;
    repeat (20) @(posedge ref_clk);
    collect(a2, a4);
    check_pat(tag, "DIV=2 pattern", a2, m2);
    check_pat(tag, "DIV=4 pattern", a4, m4);
  endtask

  initial begin
    repeat (4) @(posedge ref_clk);
    #5;
    check_bit("R8", "DIV=2 in reset (ref high)", out2, 1'b0);
    check_bit("R8", "DIV=4 in reset (ref high)", out4, 1'b0);
    @(negedge ref_clk); #5;
    rst_n = 1'b1;
    @(posedge ref_clk); #5;
    check_bit("R8", "DIV=2 after first edge", out2, 1'b1);
    check_bit("R8", "DIV=4 after first edge", out4, 1'b0);
    @(posedge ref_clk); #5;
    check_bit("R8", "DIV=4 after second edge", out4, 1'b1);
    @(negedge ref_clk); #5;

    scenario(1'b0, 1'b0, "R1 R9 nominal",              1, 2);
    scenario(1'b1, 1'b0, "R3 R4 R5 R6 stepped",        0, 1);
    scenario(1'b1, 1'b1, "R2 R5 scan masks request",   1, 2);
    scenario(1'b1, 1'b0, "R5 R6 scan released",        0, 1);
    scenario(1'b0, 1'b0, "R5 R9 request dropped",      1, 2);
    scenario(1'b0, 1'b1, "R2 scan without request",    1, 2);
    scenario(1'b1, 1'b0, "R4 R5 stepped again",        0, 1);

    checks++;
    if (viol[0] != 0) begin
      fails++;
      $display("FAIL R7 DIV=2 runt pulses: actual %0d expected 0", viol[0]);
    end
    checks++;
    if (viol[1] != 0) begin
      fails++;
      $display("FAIL R7 DIV=4 runt pulses: actual %0d expected 0", viol[1]);
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end
endmodule